// File: doc/BRIEF.md
# Event Timer With Capture and Pulse Output

A 32-bit general-purpose timer reached over a simple register bus. One upward counter serves three uses at once. It can be a free-running or reloading timer, a timestamp source for edges seen on an asynchronous capture input, and the time base for an event output pin that either pulses for one cycle or toggles. A power-of-two prescaler slows the count. Match, wrap and capture events are latched in a sticky status word that drives an interrupt line and a separate wake-up line, each through its own mask.

Register writes do not act at once. Each write is held in a staging slot for a fixed number of clock cycles and then applied, and a busy register reports the write while it is in flight. Software polls the busy register before it issues the next write. A keyed soft-reset command returns every software-visible register to its default over a fixed number of cycles, and a done flag shows when that has finished.

Register map (byte addresses): 0x00 identity, 0x04 control, 0x08 count, 0x0C reload value, 0x10 restart strobe, 0x14 compare value, 0x18 snapshot, 0x1C event status, 0x20 interrupt mask, 0x24 wake mask, 0x28 busy, 0x2C soft-reset command, 0x30 system status. Control fields: bit 0 run, bit 1 reload on wrap, bit 2 prescaler on, bits 5:3 ratio, bit 6 compare on, bits 8:7 capture edge, bit 9 pin idle level, bit 10 toggle mode, bits 12:11 pin event source, bit 13 pin drive enable.

Top module: `evt_timer`

## Requirements
- R1: After hardware reset, the control, count, reload, compare, snapshot, status and mask registers read 0. The identity register reads 0x5E710A02, busy reads 0, system status bit 0 reads 1, and the pin, drive enable, interrupt and wake outputs are 0.
- R2: A register write takes effect on the second rising edge after the edge that samples the strobe. The busy register (0x28) reads 1 for the two cycles in between and reads 0 afterwards.
- R3: With run (control bit 0) set and the prescaler off (bit 2 clear), the count rises by one every clock.
- R4: With the prescaler on, the count rises once every 2^(ratio+1) clocks, where ratio is control bits 5:3.
- R5: When the count advances from 0xFFFFFFFF with reload (bit 1) clear, it becomes 0, the run bit clears, and status bit 1 (wrap) is set.
- R6: When the count advances from 0xFFFFFFFF with reload set, it takes the reload value, keeps running, and sets status bit 1.
- R7: A write of any value to the restart register (0x10) copies the reload value into the count.
- R8: With compare on (bit 6), an advance that makes the count equal the compare value sets status bit 0 (match).
- R9: The capture input passes through two synchronising flops. On the edge that control bits 8:7 select (00 none, 01 rising, 10 falling, 11 both), the snapshot register takes the count of that cycle and status bit 2 is set.
- R10: Status bits are sticky and are cleared by writing 1 to them; a new event in the same cycle wins. The interrupt output is high when any status bit has its interrupt-mask bit set, and the wake output follows the wake mask in the same way.
- R11: Pin events come from control bits 12:11: 00 none, 01 wrap, 10 wrap or match, 11 none. In pulse mode (bit 10 clear) each event drives the pin to the inverse of the idle level (bit 9) for one cycle, registered with the count update. In toggle mode, each event flips the pin. The drive-enable output follows bit 13.
- R12: A write of 0x6 to the soft-reset register (0x2C) clears every register of R1 and keeps them cleared while system status bit 0 reads 0 for four cycles. Any other value written there has no effect.
- R13: With the run bit clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| cap_in | input | 1 | Asynchronous capture input |
| evt_out | output | 1 | Event output pin level |
| evt_oe | output | 1 | Event output pin drive enable |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The properties assume that software never issues a new write while busy reads 1. They also assume that no write is issued while a soft reset is still counting down, because a second write replaces the staged one. The stimulus keeps within both rules: every write is followed by polling the busy register until it reads 0, and after a soft reset the bench polls the done flag before it writes again. Reads have no side effects, so the bench reads freely at any time. The capture input is toggled only between bus accesses, with enough idle cycles for the synchroniser.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam logic [7:0] REG_IDENT   = 8'h00;
    localparam logic [7:0] REG_CTRL    = 8'h04;
    localparam logic [7:0] REG_COUNT   = 8'h08;
    localparam logic [7:0] REG_LOAD    = 8'h0C;
    localparam logic [7:0] REG_RESTART = 8'h10;
    localparam logic [7:0] REG_MATCH   = 8'h14;
    localparam logic [7:0] REG_SNAP    = 8'h18;
    localparam logic [7:0] REG_EVST    = 8'h1C;
    localparam logic [7:0] REG_IRQEN   = 8'h20;
    localparam logic [7:0] REG_WAKEEN  = 8'h24;
    localparam logic [7:0] REG_BUSY    = 8'h28;
    localparam logic [7:0] REG_SRST    = 8'h2C;
    localparam logic [7:0] REG_SYSST   = 8'h30;

    localparam logic [31:0] SRST_KEY = 32'h0000_0006;

    localparam int EV_W = 3;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } cap_edge_e;

    typedef enum logic [1:0] {
        OSRC_OFF      = 2'b00,
        OSRC_WRAP     = 2'b01,
        OSRC_WRAP_CMP = 2'b10,
        OSRC_RSVD     = 2'b11
    } out_src_e;

    typedef struct packed {
        logic      drv_en;
        out_src_e  out_src;
        logic      toggle;
        logic      idle_hi;
        cap_edge_e cap_edge;
        logic      cmp_en;
        logic [2:0] ratio;
        logic      pre_en;
        logic      reload;
        logic      run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/evt_timer_tick.sv
module evt_timer_tick #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic               pre_en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam int PC_W = 2 ** RATIO_W;

    logic [PC_W-1:0] pc_q, pc_d, limit;
    logic [PC_W:0]   span;

    always_comb begin
        span  = (PC_W + 1)'(1) << (int'(ratio) + 1);
        limit = span[PC_W-1:0] - 1'b1;
        tick  = run & (~pre_en | (pc_q == limit));
        pc_d  = (clr | ~run | ~pre_en | tick) ? '0 : pc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pre_en && !clr) |=> (!tick || !pre_en));

endmodule

// File: rtl/evt_timer_edge.sv
module evt_timer_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [SYNC:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[SYNC-1:0], din};
        rise = sh_q[SYNC-1] & ~sh_q[SYNC];
        fall = ~sh_q[SYNC-1] & sh_q[SYNC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

endmodule

// File: rtl/evt_timer_wstage.sv
module evt_timer_wstage #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ap_valid,
    output logic [ADDR_W-1:0] ap_addr,
    output logic [DATA_W-1:0] ap_data,
    output logic              busy
);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.cnt  = CW'(LAT);
            s_d.addr = wr_addr;
            s_d.data = wr_data;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ap_valid = (s_q.cnt == CW'(1));
    assign ap_addr  = s_q.addr;
    assign ap_data  = s_q.data;
    assign busy     = (s_q.cnt != '0);

    // R2
    busy_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy);

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          ADDR_W      = 8,
    parameter int          WR_LAT      = 2,
    parameter int          SRST_CYC    = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] IDENT       = 32'h5E71_0A02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_in,
    output logic              evt_out,
    output logic              evt_oe,
    output logic              irq,
    output logic              wake
);
    localparam int SR_W    = $clog2(SRST_CYC + 1);
    localparam int RATIO_W = 3;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] match;
        logic [DATA_W-1:0] snap;
        logic [EV_W-1:0]   st;
        logic [EV_W-1:0]   ien;
        logic [EV_W-1:0]   wen;
        logic              tog;
        logic              pin;
        logic [SR_W-1:0]   srst;
    } state_t;

    state_t s_q, s_d;

    logic              tick, cap_rise, cap_fall;
    logic              ap_valid, busy, soft_busy;
    logic [ADDR_W-1:0] ap_addr;
    logic [DATA_W-1:0] ap_data;
    logic              ev_wrap, ev_match, ev_snap, out_ev, cap_hit;
    logic [EV_W-1:0]   clr_mask;

    assign soft_busy = (s_q.srst != '0);

    evt_timer_wstage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(WR_LAT)) u_wstage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .ap_valid (ap_valid),
        .ap_addr  (ap_addr),
        .ap_data  (ap_data),
        .busy     (busy)
    );

    evt_timer_tick #(.RATIO_W(RATIO_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_busy),
        .run    (s_q.ctrl.run),
        .pre_en (s_q.ctrl.pre_en),
        .ratio  (s_q.ctrl.ratio),
        .tick   (tick)
    );

    evt_timer_edge #(.SYNC(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_in),
        .rise  (cap_rise),
        .fall  (cap_fall)
    );

    always_comb begin
        s_d      = s_q;
        ev_wrap  = 1'b0;
        ev_match = 1'b0;
        ev_snap  = 1'b0;
        out_ev   = 1'b0;
        cap_hit  = 1'b0;
        clr_mask = '0;
        if (soft_busy) begin
            s_d      = '0;
            s_d.srst = s_q.srst - 1'b1;
        end else begin
            // counter advance, wrap and compare
            if (tick) begin
                if (&s_q.cnt) begin
                    ev_wrap = 1'b1;
                    s_d.cnt = s_q.ctrl.reload ? s_q.load : '0;
                    if (!s_q.ctrl.reload) s_d.ctrl.run = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
                ev_match = s_q.ctrl.cmp_en && (s_d.cnt == s_q.match);
            end
            // capture
            case (s_q.ctrl.cap_edge)
                EDGE_RISE: cap_hit = cap_rise;
                EDGE_FALL: cap_hit = cap_fall;
                EDGE_ANY:  cap_hit = cap_rise | cap_fall;
                default:   cap_hit = 1'b0;
            endcase
            if (cap_hit) begin
                ev_snap  = 1'b1;
                s_d.snap = s_q.cnt;
            end
            // event pin
            case (s_q.ctrl.out_src)
                OSRC_WRAP:     out_ev = ev_wrap;
                OSRC_WRAP_CMP: out_ev = ev_wrap | ev_match;
                default:       out_ev = 1'b0;
            endcase
            s_d.tog = s_q.tog ^ out_ev;
            s_d.pin = s_q.ctrl.idle_hi ^ (s_q.ctrl.toggle ? s_d.tog : out_ev);
            // staged register write
            if (ap_valid) begin
                case (ap_addr)
                    ADDR_W'(REG_CTRL):    s_d.ctrl  = ctrl_t'(ap_data[CTRL_W-1:0]);
                    ADDR_W'(REG_COUNT):   s_d.cnt   = ap_data;
                    ADDR_W'(REG_LOAD):    s_d.load  = ap_data;
                    ADDR_W'(REG_RESTART): s_d.cnt   = s_q.load;
                    ADDR_W'(REG_MATCH):   s_d.match = ap_data;
                    ADDR_W'(REG_EVST):    clr_mask  = ap_data[EV_W-1:0];
                    ADDR_W'(REG_IRQEN):   s_d.ien   = ap_data[EV_W-1:0];
                    ADDR_W'(REG_WAKEEN):  s_d.wen   = ap_data[EV_W-1:0];
                    default: ;
                endcase
            end
            s_d.st = (s_q.st & ~clr_mask) | {ev_snap, ev_wrap, ev_match};
            if (ap_valid && (ap_addr == ADDR_W'(REG_SRST)) &&
                (ap_data == DATA_W'(SRST_KEY))) begin
                s_d      = '0;
                s_d.srst = SR_W'(SRST_CYC);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(REG_IDENT):  bus_rdata = DATA_W'(IDENT);
                ADDR_W'(REG_CTRL):   bus_rdata = DATA_W'(s_q.ctrl);
                ADDR_W'(REG_COUNT):  bus_rdata = s_q.cnt;
                ADDR_W'(REG_LOAD):   bus_rdata = s_q.load;
                ADDR_W'(REG_MATCH):  bus_rdata = s_q.match;
                ADDR_W'(REG_SNAP):   bus_rdata = s_q.snap;
                ADDR_W'(REG_EVST):   bus_rdata = DATA_W'(s_q.st);
                ADDR_W'(REG_IRQEN):  bus_rdata = DATA_W'(s_q.ien);
                ADDR_W'(REG_WAKEEN): bus_rdata = DATA_W'(s_q.wen);
                ADDR_W'(REG_BUSY):   bus_rdata = DATA_W'(busy);
                ADDR_W'(REG_SYSST):  bus_rdata = DATA_W'(!soft_busy);
                default:             bus_rdata = '0;
            endcase
        end
    end

    assign irq     = |(s_q.st & s_q.ien);
    assign wake    = |(s_q.st & s_q.wen);
    assign evt_out = s_q.pin;
    assign evt_oe  = s_q.ctrl.drv_en;

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.run && !s_q.ctrl.pre_en && !ap_valid && !soft_busy && !(&s_q.cnt))
        |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R5
    wrap_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&s_q.cnt) && !s_q.ctrl.reload && !ap_valid && !soft_busy)
        |=> (!s_q.ctrl.run && (s_q.cnt == '0) && s_q.st[1]));

    // R13
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.run && !ap_valid && !soft_busy) |=> $stable(s_q.cnt));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ap_valid && !soft_busy) |=> ((s_q.st & $past(s_q.st)) == $past(s_q.st)));

    // R12
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_busy |=> ((s_q.cnt == '0) && (s_q.ctrl == '0) && (s_q.st == '0)));

endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
    localparam int WR_LAT   = 2;
    localparam int SRST_CYC = 4;

    localparam logic [7:0] A_ID = 8'h00, A_CT = 8'h04, A_CN = 8'h08, A_LD = 8'h0C,
                           A_RS = 8'h10, A_MT = 8'h14, A_SN = 8'h18, A_ES = 8'h1C,
                           A_IE = 8'h20, A_WE = 8'h24, A_BY = 8'h28, A_SR = 8'h2C,
                           A_SS = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  baddr = '0;
    logic [31:0] bwdata = '0;
    logic        bwr = 1'b0, brd = 1'b0, bcap = 1'b0;
    logic [31:0] brdata;
    logic        evt_out, evt_oe, irq, wake;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    evt_timer u_evt_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(baddr), .bus_wdata(bwdata),
        .bus_wr(bwr), .bus_rd(brd), .bus_rdata(brdata), .cap_in(bcap),
        .evt_out(evt_out), .evt_oe(evt_oe), .irq(irq), .wake(wake)
    );

    // ---------------- behavioural reference model ----------------
    typedef struct { int due; logic [7:0] a; logic [31:0] d; } wr_t;
    wr_t wq[$];

    logic [13:0] m_ctrl;
    logic [31:0] m_cnt, m_ld, m_mt, m_snap;
    logic [2:0]  m_st, m_ie, m_we;
    logic        m_tog, m_out;
    int          m_srst, m_pc;
    logic [2:0]  m_sy;

    task automatic clr_regs();
        m_ctrl = '0; m_cnt = '0; m_ld = '0; m_mt = '0; m_snap = '0;
        m_st = '0; m_ie = '0; m_we = '0; m_tog = 1'b0; m_out = 1'b0;
    endtask

    initial begin
        clr_regs();
        m_srst = 0; m_pc = 0; m_sy = '0;
    end

    always @(posedge clk or negedge rst_n) begin : model
        logic ap, rise, fall, tk, wrapev, mev, cev, oev, ntog, key;
        logic [7:0]  aa;
        logic [31:0] ad, ncnt;
        logic [13:0] nctrl;
        logic [2:0]  clr;
        int          npc;
        if (!rst_n) begin
            clr_regs();
            wq.delete();
            m_srst = 0; m_pc = 0; m_sy = '0;
        end else begin
            ap = 1'b0; aa = '0; ad = '0;
            if (wq.size() != 0) begin
                if (wq[0].due == 1) begin
                    ap = 1'b1; aa = wq[0].a; ad = wq[0].d;
                    void'(wq.pop_front());
                end else begin
                    wq[0].due = wq[0].due - 1;
                end
            end
            if (bwr) wq.push_back('{due: WR_LAT, a: baddr, d: bwdata});
            rise = m_sy[1] && !m_sy[2];
            fall = !m_sy[1] && m_sy[2];
            m_sy = {m_sy[1], m_sy[0], bcap};
            if (m_srst > 0) begin
                clr_regs();
                m_pc = 0;
                m_srst = m_srst - 1;
            end else begin
                tk = m_ctrl[0] && (!m_ctrl[2] || m_pc == ((1 << (int'(m_ctrl[5:3]) + 1)) - 1));
                npc = (!m_ctrl[0] || !m_ctrl[2] || tk) ? 0 : m_pc + 1;
                nctrl = m_ctrl; ncnt = m_cnt; wrapev = 0; mev = 0; cev = 0;
                if (tk) begin
                    if (m_cnt == 32'hFFFF_FFFF) begin
                        wrapev = 1'b1;
                        if (m_ctrl[1]) ncnt = m_ld;
                        else begin ncnt = '0; nctrl[0] = 1'b0; end
                    end else ncnt = m_cnt + 1;
                    mev = m_ctrl[6] && (ncnt == m_mt);
                end
                case (m_ctrl[8:7])
                    2'd1: cev = rise;
                    2'd2: cev = fall;
                    2'd3: cev = rise || fall;
                    default: cev = 1'b0;
                endcase
                if (cev) m_snap = m_cnt;
                oev = (m_ctrl[12:11] == 2'd1) ? wrapev :
                      (m_ctrl[12:11] == 2'd2) ? (wrapev || mev) : 1'b0;
                ntog = m_tog ^ oev;
                m_out = m_ctrl[9] ^ (m_ctrl[10] ? ntog : oev);
                m_tog = ntog;
                clr = '0; key = 1'b0;
                if (ap) begin
                    case (aa)
                        A_CT: nctrl = ad[13:0];
                        A_CN: ncnt = ad;
                        A_LD: m_ld = ad;
                        A_RS: ncnt = m_ld;
                        A_MT: m_mt = ad;
                        A_ES: clr = ad[2:0];
                        A_IE: m_ie = ad[2:0];
                        A_WE: m_we = ad[2:0];
                        A_SR: key = (ad == 32'h6);
                        default: ;
                    endcase
                end
                m_st = (m_st & ~clr) | {cev, wrapev, mev};
                m_ctrl = nctrl; m_cnt = ncnt; m_pc = npc;
                if (key) begin clr_regs(); m_srst = SRST_CYC; end
            end
        end
    end

    function automatic logic [31:0] model_read(logic [7:0] a);
        case (a)
            A_ID: return 32'h5E71_0A02;
            A_CT: return {18'b0, m_ctrl};
            A_CN: return m_cnt;
            A_LD: return m_ld;
            A_MT: return m_mt;
            A_SN: return m_snap;
            A_ES: return {29'b0, m_st};
            A_IE: return {29'b0, m_ie};
            A_WE: return {29'b0, m_we};
            A_BY: return {31'b0, wq.size() != 0};
            A_SS: return {31'b0, m_srst == 0};
            default: return '0;
        endcase
    endfunction

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10 irq line", {31'b0, irq}, {31'b0, |(m_st & m_ie)});
            chk("R10 wake line", {31'b0, wake}, {31'b0, |(m_st & m_we)});
            chk("R11 pin level", {31'b0, evt_out}, {31'b0, m_out});
            chk("R11 drive enable", {31'b0, evt_oe}, {31'b0, m_ctrl[13]});
        end
    end

    task automatic rd_chk(logic [7:0] a, string tag);
        @(negedge clk);
        bwr = 1'b0; brd = 1'b1; baddr = a;
        #2;
        chk(tag, brdata, model_read(a));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bwr = 1'b0; brd = 1'b0;
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bwr = 1'b1; brd = 1'b0; baddr = a; bwdata = d;
        for (int i = 0; i < 8; i++) begin
            rd_chk(A_BY, "R2 busy while write in flight");
            if (brdata == 32'h0) break;
        end
    endtask

    task automatic watch_count(int n, string tag);
        for (int i = 0; i < n; i++) rd_chk(A_CN, tag);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(A_ID, "R1 identity");
        chk("R1 identity literal", brdata, 32'h5E71_0A02);
        rd_chk(A_CT, "R1 control");
        rd_chk(A_CN, "R1 count");
        rd_chk(A_ES, "R1 status");
        rd_chk(A_BY, "R1 busy");
        rd_chk(A_SS, "R1 done flag");
        chk("R1 done literal", brdata, 32'h1);

        // R2 write latency and R7 restart
        @(negedge clk);
        bwr = 1'b1; brd = 1'b0; baddr = A_LD; bwdata = 32'hFFFF_FFF0;
        rd_chk(A_BY, "R2 busy cycle 1");
        chk("R2 busy literal", brdata, 32'h1);
        rd_chk(A_LD, "R2 not yet applied");
        rd_chk(A_LD, "R2 applied");
        chk("R2 applied literal", brdata, 32'hFFFF_FFF0);
        wr_reg(A_RS, 32'h1234);
        rd_chk(A_CN, "R7 restart copies reload");
        chk("R7 literal", brdata, 32'hFFFF_FFF0);

        // R3 R5 R8 R11: one-shot run, compare, pulse on wrap or match
        wr_reg(A_MT, 32'hFFFF_FFF8);
        wr_reg(A_IE, 32'h3);
        wr_reg(A_WE, 32'h4);
        wr_reg(A_CT, 32'h3041);
        watch_count(25, "R3 R5 R8 count run to wrap");
        rd_chk(A_CT, "R5 run bit cleared at wrap");
        rd_chk(A_ES, "R8 match and wrap status");
        idle(3);
        rd_chk(A_CN, "R13 stopped count holds");

        // R10 write-one-to-clear
        wr_reg(A_ES, 32'h1);
        rd_chk(A_ES, "R10 clear match only");
        wr_reg(A_ES, 32'h2);
        rd_chk(A_ES, "R10 clear wrap");

        // R6 R11 auto-reload, toggle, idle high
        wr_reg(A_LD, 32'hFFFF_FFFA);
        wr_reg(A_RS, 32'h0);
        wr_reg(A_CT, 32'h0E03);
        watch_count(30, "R6 reload on wrap");
        rd_chk(A_ES, "R6 wrap status");

        // R13 stop
        wr_reg(A_CT, 32'h0);
        rd_chk(A_CN, "R13 hold a");
        idle(5);
        rd_chk(A_CN, "R13 hold b");

        // R4 prescaler
        wr_reg(A_CN, 32'h0);
        wr_reg(A_CT, 32'h15);
        watch_count(40, "R4 divide by 8");
        wr_reg(A_CT, 32'h05);
        watch_count(10, "R4 divide by 2");
        wr_reg(A_CT, 32'h3D);
        watch_count(20, "R4 divide by 256");

        // R9 capture edges
        wr_reg(A_ES, 32'h7);
        wr_reg(A_IE, 32'h4);
        wr_reg(A_CT, 32'h81);
        idle(2); bcap = 1'b1; idle(5);
        rd_chk(A_SN, "R9 rising snapshot");
        rd_chk(A_ES, "R9 capture status");
        bcap = 1'b0; idle(5);
        rd_chk(A_SN, "R9 falling ignored when rising selected");
        wr_reg(A_ES, 32'h4);
        wr_reg(A_CT, 32'h101);
        bcap = 1'b1; idle(5);
        rd_chk(A_ES, "R9 rising ignored when falling selected");
        bcap = 1'b0; idle(5);
        rd_chk(A_SN, "R9 falling snapshot");
        wr_reg(A_CT, 32'h181);
        bcap = 1'b1; idle(5);
        rd_chk(A_SN, "R9 both edges rise");
        bcap = 1'b0; idle(5);
        rd_chk(A_SN, "R9 both edges fall");
        wr_reg(A_ES, 32'h4);
        wr_reg(A_CT, 32'h01);
        bcap = 1'b1; idle(5); bcap = 1'b0; idle(5);
        rd_chk(A_ES, "R9 no edge selected");
        rd_chk(A_SN, "R9 snapshot unchanged");

        // R12 soft reset
        wr_reg(A_SR, 32'h5);
        rd_chk(A_CT, "R12 wrong key ignored");
        rd_chk(A_SS, "R12 done after wrong key");
        @(negedge clk);
        bwr = 1'b1; brd = 1'b0; baddr = A_SR; bwdata = 32'h6;
        for (int i = 0; i < 8; i++) rd_chk(A_SS, "R12 done flag sequence");
        rd_chk(A_CT, "R12 control cleared");
        rd_chk(A_CN, "R12 count cleared");
        rd_chk(A_LD, "R12 reload cleared");
        idle(2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule